// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns a small set of active-low external interrupt pins into interrupt-pending flags that a downstream priority arbiter can use. Each pin first passes through a synchronizer that resets high, the inactive level. A mode bit for each channel then selects one of two detection styles. In level mode the flag is a live, unlatched copy of the pin. In edge mode a synchronized high-to-low transition latches the flag.

In edge mode the latched flag is cleared when the CPU acknowledges the channel. The acknowledge is a one-cycle pulse issued when the CPU vectors to that channel's service routine. Software can also load the latched flag through a per-channel write strobe. In level mode the flag stays asserted for as long as the pin is held low. A source that keeps its pin low through service therefore raises the request again. A single edge pends exactly once.

Top module: `xint_cond`

## Requirements
- R1: Each pin passes through a synchronizer of SYNC_STAGES flops (default 2) that resets to 1. With the default, a pin change shows on a level-mode `pending` bit on the second rising clock edge after the change.
- R2: When `mode_we` is 1, `mode_q` loads `mode_wdata` on the clock edge. Mode encoding: 0 = level, 1 = falling edge.
- R3: In level mode, `pending[i]` is 1 exactly while the synchronized pin is 0. Nothing is latched, so the bit falls once the pin has been high for two clocks.
- R4: In level mode, an acknowledge does not clear `pending[i]` while the pin is still low. The request therefore re-pends after service.
- R5: In edge mode, a synchronized 1-to-0 transition sets `pending[i]`. With two sync stages, the bit is 1 on the third rising edge after the pin falls.
- R6: In edge mode, `ack[i]` clears `pending[i]` on the next edge. The bit then stays 0 even while the pin stays low, so one edge pends only once.
- R7: If a detected falling edge and `ack[i]` occur in the same cycle, `pending[i]` is 1 afterwards.
- R8: In edge mode, `flag_we[i]` loads `flag_wdata[i]` into `pending[i]`. A write overrides a same-cycle acknowledge. A same-cycle detected edge overrides a write.
- R9: In level mode, flag writes have no effect. The latched flag is held at 0, so switching a channel to edge mode starts with `pending[i]` at 0.
- R10: After reset, `pending` is all 0 and `mode_q` is all 0 (level).
- R11: Channels are independent. An acknowledge, write or pin change on one channel leaves the other channel's flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | NUM_CH | Raw active-low interrupt pins, asynchronous |
| ack | input | NUM_CH | One-cycle acknowledge per channel, issued on vectoring |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | NUM_CH | New mode bits (0 level, 1 edge) |
| flag_we | input | NUM_CH | Per-channel pending flag write strobe |
| flag_wdata | input | NUM_CH | Value written to the flag |
| mode_q | output | NUM_CH | Current mode bits |
| pending | output | NUM_CH | Interrupt-pending flags to the arbiter |

## Verification
The edge-mode properties assume the mode register does not change in the cycle under test, so they are gated on `mode_we` being 0. The level-mode tracking property assumes two sync stages and at least three clocks since reset. The stimulus writes the mode only between pin and acknowledge sequences. It also holds each pin level for several clocks, so every transition passes through the synchronizer as a clean step. Acknowledges and edges are placed in the same cycle on purpose, only where the priority rules are being exercised.

// File: rtl/xint_pkg.sv
package xint_pkg;
   typedef enum logic {
      XI_LEVEL = 1'b0,
      XI_EDGE  = 1'b1
   } xi_mode_e;

   localparam int XI_MIN_SYNC = 2;
   localparam logic XI_PIN_IDLE = 1'b1;
endpackage

// File: rtl/xint_sync.sv
module xint_sync
   import xint_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] chain;

   generate
      if (STAGES < XI_MIN_SYNC) begin : g_bad_depth
         $error("xint_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{XI_PIN_IDLE}};
      end else begin
         chain <= {chain[LAST-1:0], d};
      end
   end

   assign q = chain[LAST];
endmodule

// File: rtl/xint_fall_det.sv
module xint_fall_det
   import xint_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic fall
);
   logic lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d <= XI_PIN_IDLE;
      end else begin
         lvl_d <= lvl;
      end
   end

   assign fall = lvl_d & ~lvl;
endmodule

// File: rtl/xint_chan.sv
module xint_chan
   import xint_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  xi_mode_e mode,
   input  logic     lvl,
   input  logic     fall,
   input  logic     ack,
   input  logic     wr_en,
   input  logic     wr_data,
   output logic     pending
);
   logic latched;

   // precedence: level mode holds clear, then edge, then write, then ack
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latched <= 1'b0;
      end else if (mode == XI_LEVEL) begin
         latched <= 1'b0;
      end else if (fall) begin
         latched <= 1'b1;
      end else if (wr_en) begin
         latched <= wr_data;
      end else if (ack) begin
         latched <= 1'b0;
      end
   end

   always_comb begin
      if (mode == XI_EDGE) pending = latched;
      else                 pending = ~lvl;
   end
endmodule

// File: rtl/xint_cond.sv
module xint_cond
   import xint_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pin_n,
   input  logic [NUM_CH-1:0] ack,
   input  logic              mode_we,
   input  logic [NUM_CH-1:0] mode_wdata,
   input  logic [NUM_CH-1:0] flag_we,
   input  logic [NUM_CH-1:0] flag_wdata,
   output logic [NUM_CH-1:0] mode_q,
   output logic [NUM_CH-1:0] pending
);
   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("xint_cond: NUM_CH must be at least 1");
      end
   endgenerate

   logic [NUM_CH-1:0] mode_r;
   logic [NUM_CH-1:0] sync_w;
   logic [NUM_CH-1:0] fall_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_r <= '0;
      end else if (mode_we) begin
         mode_r <= mode_wdata;
      end
   end

   assign mode_q = mode_r;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      xint_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (pin_n[i]),
         .q     (sync_w[i])
      );

      xint_fall_det u_fall (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl   (sync_w[i]),
         .fall  (fall_w[i])
      );

      xint_chan u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .mode    (xi_mode_e'(mode_r[i])),
         .lvl     (sync_w[i]),
         .fall    (fall_w[i]),
         .ack     (ack[i]),
         .wr_en   (flag_we[i]),
         .wr_data (flag_wdata[i]),
         .pending (pending[i])
      );
   end
endmodule

// File: rtl/xint_cond_chk.sv
module xint_cond_chk #(
   parameter int NUM_CH      = 2,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] pin_n,
   input logic [NUM_CH-1:0] ack,
   input logic              mode_we,
   input logic [NUM_CH-1:0] mode_wdata,
   input logic [NUM_CH-1:0] flag_we,
   input logic [NUM_CH-1:0] flag_wdata,
   input logic [NUM_CH-1:0] mode_q,
   input logic [NUM_CH-1:0] pending,
   input logic [NUM_CH-1:0] fall
);
   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      // R6
      ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q[i] && ack[i] && !fall[i] && !flag_we[i] && !mode_we) |=> !pending[i]);

      // R5 R7
      edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q[i] && fall[i] && !mode_we) |=> pending[i]);

      // R8
      sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_q[i] && flag_we[i] && !fall[i] && !mode_we) |=> (pending[i] == $past(flag_wdata[i])));

      // R9
      switch_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!mode_q[i] && mode_we && mode_wdata[i]) |=> !pending[i]);

      if (SYNC_STAGES == 2) begin : g_lvl
         // R3
         level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_q[i] && since_rst == 2'd3) |-> (pending[i] == !$past(pin_n[i], 2)));
      end
   end
endmodule

bind xint_cond xint_cond_chk #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pin_n      (pin_n),
   .ack        (ack),
   .mode_we    (mode_we),
   .mode_wdata (mode_wdata),
   .flag_we    (flag_we),
   .flag_wdata (flag_wdata),
   .mode_q     (mode_q),
   .pending    (pending),
   .fall       (fall_w)
);

// File: tb/xint_cond_bench.sv
module xint_cond_bench;
   localparam int NCH = 2;
   localparam int NS  = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] pin_n = '1;
   logic [NCH-1:0] ack = '0;
   logic           mode_we = 1'b0;
   logic [NCH-1:0] mode_wdata = '0;
   logic [NCH-1:0] flag_we = '0;
   logic [NCH-1:0] flag_wdata = '0;
   logic [NCH-1:0] mode_q;
   logic [NCH-1:0] pending;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   xint_cond #(.NUM_CH(NCH), .SYNC_STAGES(NS)) u_xint_cond (
      .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .ack(ack),
      .mode_we(mode_we), .mode_wdata(mode_wdata),
      .flag_we(flag_we), .flag_wdata(flag_wdata),
      .mode_q(mode_q), .pending(pending)
   );

   // behavioural reference: history of pin samples per channel
   bit hq [NCH][$];
   bit m_ef [NCH];
   bit m_mode [NCH];
   bit m_pend [NCH];

   task automatic model_reset();
      for (int c = 0; c < NCH; c++) begin
         hq[c] = {};
         for (int k = 0; k <= NS; k++) hq[c].push_back(1'b1);
         m_ef[c] = 1'b0;
         m_mode[c] = 1'b0;
         m_pend[c] = 1'b0;
      end
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         for (int c = 0; c < NCH; c++) begin
            bit f;
            f = hq[c][0] && !hq[c][1];
            if (!m_mode[c])         m_ef[c] = 1'b0;
            else if (f)             m_ef[c] = 1'b1;
            else if (flag_we[c])    m_ef[c] = flag_wdata[c];
            else if (ack[c])        m_ef[c] = 1'b0;
            hq[c].push_back(pin_n[c]);
            void'(hq[c].pop_front());
         end
         if (mode_we)
            for (int c = 0; c < NCH; c++) m_mode[c] = mode_wdata[c];
         for (int c = 0; c < NCH; c++)
            m_pend[c] = m_mode[c] ? m_ef[c] : !hq[c][1];
      end
   end

   task automatic check(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            check(m_mode[c] ? "R5 edge-mode model" : "R3 level-mode model",
                  pending[c], m_pend[c]);
            check("R2 mode model", mode_q[c], m_mode[c]);
         end
      end
      if (cyc > 20000) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog act=hung exp=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_mode(logic [NCH-1:0] v);
      mode_we = 1'b1; mode_wdata = v; step(1);
      mode_we = 1'b0; step(1);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R10
      check("R10 pending reset", pending[0] | pending[1], 1'b0);
      check("R10 mode reset", mode_q[0] | mode_q[1], 1'b0);

      // R1 R3 level tracking and latency
      pin_n[0] = 1'b0;
      step(1);
      check("R1 not yet after 1 edge", pending[0], 1'b0);
      step(1);
      check("R1 R3 level after 2 edges", pending[0], 1'b1);
      // R4 ack while still low
      ack[0] = 1'b1; step(1); ack[0] = 1'b0; step(2);
      check("R4 level re-pend", pending[0], 1'b1);
      // R9 write ignored in level mode
      flag_we[1] = 1'b1; flag_wdata[1] = 1'b1; step(1); flag_we[1] = 1'b0; step(1);
      check("R9 level write ignored", pending[1], 1'b0);
      pin_n[0] = 1'b1; step(3);
      check("R3 level clears", pending[0], 1'b0);

      // R2 R9 switch to edge mode with stale pin low on ch1
      pin_n[1] = 1'b0; step(4); pin_n[1] = 1'b1; step(4);
      wr_mode(2'b11);
      check("R2 mode loaded", mode_q[0] & mode_q[1], 1'b1);
      check("R9 edge starts clear", pending[1], 1'b0);

      // R5 R6 single edge pends once
      pin_n[0] = 1'b0; step(2);
      check("R5 not yet", pending[0], 1'b0);
      step(1);
      check("R5 edge sets", pending[0], 1'b1);
      check("R11 other channel idle", pending[1], 1'b0);
      ack[0] = 1'b1; step(1); ack[0] = 1'b0;
      check("R6 ack clears", pending[0], 1'b0);
      step(5);
      check("R6 held low no re-pend", pending[0], 1'b0);
      pin_n[0] = 1'b1; step(4);

      // R8 software write in edge mode
      flag_we[1] = 1'b1; flag_wdata[1] = 1'b1; step(1); flag_we[1] = 1'b0;
      check("R8 write sets", pending[1], 1'b1);
      check("R11 ch0 untouched", pending[0], 1'b0);
      flag_we[1] = 1'b1; flag_wdata[1] = 1'b1; ack[1] = 1'b1; step(1);
      flag_we[1] = 1'b0; ack[1] = 1'b0;
      check("R8 write beats ack", pending[1], 1'b1);

      // R7 edge coincident with ack keeps flag set
      pin_n[1] = 1'b0; step(2);
      ack[1] = 1'b1; step(1); ack[1] = 1'b0;
      check("R7 set wins over ack", pending[1], 1'b1);
      // R8 edge beats clearing write
      pin_n[1] = 1'b1; step(4);
      ack[1] = 1'b1; step(1); ack[1] = 1'b0;
      check("R6 cleared", pending[1], 1'b0);
      pin_n[1] = 1'b0; step(2);
      flag_we[1] = 1'b1; flag_wdata[1] = 1'b0; step(1); flag_we[1] = 1'b0;
      check("R8 edge beats write", pending[1], 1'b1);
      flag_we[1] = 1'b1; flag_wdata[1] = 1'b0; step(1); flag_we[1] = 1'b0;
      check("R8 write clears", pending[1], 1'b0);
      pin_n[1] = 1'b1; step(3);

      // back to level with both pins low: R3 R11
      wr_mode(2'b00);
      pin_n = 2'b00; step(3);
      check("R3 ch0 level", pending[0], 1'b1);
      check("R3 ch1 level", pending[1], 1'b1);
      pin_n = 2'b10; step(3);
      check("R11 ch1 cleared alone", pending[1], 1'b0);
      check("R11 ch0 still low", pending[0], 1'b1);
      pin_n = 2'b11; step(4);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule